// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Set/Clear Control

This block is a bank of general-purpose pins controlled through a small word-addressed register port (address, write enable, write data, combinational read data). Output level and pin direction are never written as whole words. Each has a pair of strobe registers. Writing ones to the "raise" register sets the chosen bits and writing ones to the "lower" register clears them. Software can therefore change one pin without a read-modify-write sequence that might race with another agent.

Each pin has four further settings. A pull-off bit turns off its pull resistor. Two independent alternate-select planes give a two-bit function code, which an outside pad multiplexer uses to hand the pad to GPIO or to peripheral function A, B or C. A sleep-keep bit says whether the pin holds its state in sleep or is armed for wakeup. Pad inputs pass through a synchronizer, and the synchronized levels are brought out so that a separate edge-interrupt block can use them.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0) with `pad_out` all 0, pull enabled (`pull_en` all 1), function code 00, and `sleep_keep` all 0. Every readable register reads 0.
- R2: A write to word offset 0x04 sets to 1 the output-data bit of every pin whose write bit is 1. Other bits keep their value. The output data appears on `pad_out` from the clock edge that takes the write.
- R3: A write to offset 0x08 clears the output-data bit of every pin whose write bit is 1. Other bits keep their value.
- R4: A write to 0x14 makes the selected pins outputs and a write to 0x18 makes them inputs. Zero bits are unchanged. Direction reads back at 0x10, with 1 meaning output, and drives `pad_oe`.
- R5: Reading offset 0x00 returns the pin levels after a two-flop synchronizer. A change on `pad_in` is seen on read and on `pin_level` after exactly two clock edges, and not after one.
- R6: The planes at 0x20 (A) and 0x24 (B) are read/write. The function code of pin i is `func_sel[2i+1:2i]` = {B[i], A[i]}: 00 is GPIO, 01 is function A, 10 is function B and 11 is function C.
- R7: The register at 0x0C is read/write. A bit of 1 turns that pin's pull off, so `pull_en[i]` is the inverse of the stored bit.
- R8: The register at 0x1C is read/write and drives `sleep_keep`. A bit of 1 keeps the pin's state in sleep and a bit of 0 arms wakeup.
- R9: A read returns 0 at any address outside the ten offsets, at any address with nonzero low two bits, and at the four set/clear offsets. A write to such an address, or to 0x00 or 0x10, changes no state.
- R10: When `wr_en` is 0, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (6) | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, bit i for pin i |
| rd_data | output | 32 | Read data for `addr` |
| pad_in | input | NPIN (32) | Raw level seen at each pad |
| pad_out | output | NPIN | Output data to each pad driver |
| pad_oe | output | NPIN | Output enable to each pad driver |
| pull_en | output | NPIN | Pull resistor enable per pad |
| func_sel | output | 2*NPIN | Two-bit function code per pin |
| sleep_keep | output | NPIN | Per-pin sleep behaviour (1 keep, 0 wake) |
| pin_level | output | NPIN | Synchronized pad levels for the edge-interrupt block |

## Verification
The hardest behaviour to reach from the ports is the synchronizer latency. The bench has to show that a pad change is hidden after one edge and visible after the second. To do this, the stimulus changes the external pad drive at a falling edge while the pins are inputs, then reads offset 0x00 at the next two falling edges. A second detail is that the level read back for an output pin is the driven value coming back through the pad. The bench models the pad as a loopback when `pad_oe` is set, so data set/clear writes can be checked through the level register two cycles after `pad_out` changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned IDX_W = 4;

   // word index of each register (byte offset / 4)
   typedef enum logic [IDX_W-1:0] {
      IDX_LEVEL    = 4'd0,
      IDX_OUT_SET  = 4'd1,
      IDX_OUT_CLR  = 4'd2,
      IDX_PULL_OFF = 4'd3,
      IDX_DIR      = 4'd4,
      IDX_DIR_SET  = 4'd5,
      IDX_DIR_CLR  = 4'd6,
      IDX_SLEEP    = 4'd7,
      IDX_ALT_A    = 4'd8,
      IDX_ALT_B    = 4'd9
   } reg_idx_e;

   localparam int unsigned LAST_IDX = 9;

   typedef enum logic [1:0] {
      FN_GPIO = 2'b00,
      FN_A    = 2'b01,
      FN_B    = 2'b10,
      FN_C    = 2'b11
   } pin_fn_e;

   function automatic pin_fn_e fn_code(input logic a_bit, input logic b_bit);
      return pin_fn_e'({b_bit, a_bit});
   endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "gpio_bank_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            chain[k] <= chain[k-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_w1sc.sv
module gpio_bank_w1sc #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);
   logic [W-1:0] set_mask;
   logic [W-1:0] clr_mask;

   assign set_mask = set_we ? bits : '0;
   assign clr_mask = clr_we ? bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_mask) & ~clr_mask;
   end

   // R2 / R4: every bit named by a set strobe is 1 afterwards
   a_r2_set_bits : assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(bits)) == $past(bits)));

   // R3 / R4: every bit named by a clear strobe is 0 afterwards
   a_r3_clr_bits : assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((q & $past(bits)) == '0));

   // R2 / R3: bits not named by a strobe keep their value
   a_r3_others_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (set_we || clr_we) |=> ((q & ~$past(bits)) == ($past(q) & ~$past(bits))));

   // R10: no strobe, no change
   a_r10_w1sc_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/gpio_bank_plane.sv
module gpio_bank_plane #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   // R10: a plane changes only when written
   a_r10_plane_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   // R6 / R7 / R8: a written value is stored
   a_r6_plane_store : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_idx_e          idx
);
   initial begin
      assert (ADDR_W >= 6) else $fatal(1, "gpio_bank_decode: ADDR_W must be at least 6");
   end

   logic hi_zero;

   if (ADDR_W > 6) begin : g_wide
      assign hi_zero = ~|addr[ADDR_W-1:6];
   end else begin : g_narrow
      assign hi_zero = 1'b1;
   end

   assign idx = reg_idx_e'(addr[5:2]);
   assign hit = hi_zero && (addr[1:0] == 2'b00) && (addr[5:2] <= IDX_W'(LAST_IDX));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN-1:0]   pull_en,
   output logic [2*NPIN-1:0] func_sel,
   output logic [NPIN-1:0]   sleep_keep,
   output logic [NPIN-1:0]   pin_level
);
   initial begin
      assert (NPIN >= 1 && NPIN <= REG_W) else $fatal(1, "gpio_bank: NPIN out of range");
   end

   logic     hit;
   reg_idx_e idx;

   gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .hit  (hit),
      .idx  (idx)
   );

   logic wr_hit;
   assign wr_hit = wr_en && hit;

   logic [NPIN-1:0] wbits;
   assign wbits = wr_data[NPIN-1:0];

   // atomic set/clear state
   logic [NPIN-1:0] out_q, dir_q;

   gpio_bank_w1sc #(.W(NPIN)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_hit && idx == IDX_OUT_SET),
      .clr_we (wr_hit && idx == IDX_OUT_CLR),
      .bits   (wbits),
      .q      (out_q)
   );

   gpio_bank_w1sc #(.W(NPIN)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_hit && idx == IDX_DIR_SET),
      .clr_we (wr_hit && idx == IDX_DIR_CLR),
      .bits   (wbits),
      .q      (dir_q)
   );

   // plain read/write planes
   logic [NPIN-1:0] pull_off_q, sleep_q, alt_a_q, alt_b_q;

   gpio_bank_plane #(.W(NPIN)) u_pull (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit && idx == IDX_PULL_OFF), .d (wbits), .q (pull_off_q));

   gpio_bank_plane #(.W(NPIN)) u_sleep (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit && idx == IDX_SLEEP), .d (wbits), .q (sleep_q));

   gpio_bank_plane #(.W(NPIN)) u_alt_a (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit && idx == IDX_ALT_A), .d (wbits), .q (alt_a_q));

   gpio_bank_plane #(.W(NPIN)) u_alt_b (
      .clk (clk), .rst_n (rst_n),
      .we  (wr_hit && idx == IDX_ALT_B), .d (wbits), .q (alt_b_q));

   // input synchronizer
   gpio_bank_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_level)
   );

   // pad-side outputs
   assign pad_out    = out_q;
   assign pad_oe     = dir_q;
   assign pull_en    = ~pull_off_q;
   assign sleep_keep = sleep_q;

   for (genvar i = 0; i < NPIN; i++) begin : g_fn
      assign func_sel[2*i +: 2] = fn_code(alt_a_q[i], alt_b_q[i]);
   end

   // read mux
   function automatic logic [31:0] widen(input logic [NPIN-1:0] v);
      logic [31:0] r;
      r = '0;
      r[NPIN-1:0] = v;
      return r;
   endfunction

   always_comb begin
      rd_data = '0;
      if (hit) begin
         unique case (idx)
            IDX_LEVEL:    rd_data = widen(pin_level);
            IDX_PULL_OFF: rd_data = widen(pull_off_q);
            IDX_DIR:      rd_data = widen(dir_q);
            IDX_SLEEP:    rd_data = widen(sleep_q);
            IDX_ALT_A:    rd_data = widen(alt_a_q);
            IDX_ALT_B:    rd_data = widen(alt_b_q);
            default:      rd_data = '0;
         endcase
      end
   end

   // R1: a cycle held in reset leaves every pin an undriven input with pull on
   a_r1_reset_state : assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0 && pull_en == '1 && func_sel == '0));

   // R9: a write outside the map leaves the pad controls alone
   a_r9_stray_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(func_sel)));

   // R4: direction never changes without a write to a direction strobe
   a_r4_dir_source : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && (idx == IDX_DIR_SET || idx == IDX_DIR_CLR)) |=> $stable(pad_oe));
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
   localparam int NPIN = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [5:0]        addr = '0;
   logic              wr_en = 1'b0;
   logic [31:0]       wr_data = '0;
   logic [31:0]       rd_data;
   logic [NPIN-1:0]   pad_in;
   logic [NPIN-1:0]   pad_out, pad_oe, pull_en, sleep_keep, pin_level;
   logic [2*NPIN-1:0] func_sel;
   logic [NPIN-1:0]   ext_drv = '0;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   // pad model: driven pins loop back, others follow the outside world
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv);

   gpio_bank #(.NPIN(NPIN)) u0 (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
      .wr_data (wr_data), .rd_data (rd_data), .pad_in (pad_in),
      .pad_out (pad_out), .pad_oe (pad_oe), .pull_en (pull_en),
      .func_sel (func_sel), .sleep_keep (sleep_keep), .pin_level (pin_level)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 pad_oe", 64'(pad_oe), 64'h0);
      chk("R1 pad_out", 64'(pad_out), 64'h0);
      chk("R1 pull_en", 64'(pull_en), 64'hFFFF_FFFF);
      chk("R1 func_sel", func_sel, 64'h0);
      chk("R1 sleep_keep", 64'(sleep_keep), 64'h0);
      for (int a = 0; a < 10; a++) begin
         rd(6'(a*4), v);
         chk("R1 register reset", 64'(v), 64'h0);
      end
   endtask

   task automatic t_direction();
      logic [31:0] v;
      wr(6'h14, 32'hF0F0_00FF);
      chk("R4 dir set pad_oe", 64'(pad_oe), 64'hF0F0_00FF);
      wr(6'h18, 32'h0000_000F);
      chk("R4 dir clear pad_oe", 64'(pad_oe), 64'hF0F0_00F0);
      rd(6'h10, v);
      chk("R4 dir readback", 64'(v), 64'hF0F0_00F0);
      wr(6'h14, 32'h0F0F_FF0F);
      rd(6'h10, v);
      chk("R4 dir all outputs", 64'(v), 64'hFFFF_FFFF);
   endtask

   task automatic t_data();
      logic [31:0] v;
      wr(6'h04, 32'hA5A5_0001);
      chk("R2 data set", 64'(pad_out), 64'hA5A5_0001);
      wr(6'h04, 32'h0000_0100);
      chk("R2 data set keeps others", 64'(pad_out), 64'hA5A5_0101);
      wr(6'h08, 32'h8000_0001);
      chk("R3 data clear", 64'(pad_out), 64'h25A5_0100);
      wr(6'h08, 32'h0);
      chk("R3 zero clear no change", 64'(pad_out), 64'h25A5_0100);
      @(negedge clk); @(negedge clk);
      rd(6'h00, v);
      chk("R5 loopback level", 64'(v), 64'h25A5_0100);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      wr(6'h18, 32'hFFFF_FFFF);  // all inputs
      ext_drv = 32'h1234_5678;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rd(6'h00, v);
      chk("R5 settled level", 64'(v), 64'h1234_5678);
      ext_drv = 32'hCAFE_0F0F;          // change at a falling edge
      @(negedge clk);
      rd(6'h00, v);
      chk("R5 hidden after one edge", 64'(v), 64'h1234_5678);
      @(negedge clk);
      rd(6'h00, v);
      chk("R5 visible after two edges", 64'(v), 64'hCAFE_0F0F);
      chk("R5 pin_level", 64'(pin_level), 64'hCAFE_0F0F);
   endtask

   task automatic t_func();
      logic [31:0] v;
      wr(6'h20, 32'h0000_000A);   // pins 1,3 A
      wr(6'h24, 32'h0000_000C);   // pins 2,3 B
      chk("R6 pin0 gpio", 64'(func_sel[1:0]), 64'h0);
      chk("R6 pin1 func A", 64'(func_sel[3:2]), 64'h1);
      chk("R6 pin2 func B", 64'(func_sel[5:4]), 64'h2);
      chk("R6 pin3 func C", 64'(func_sel[7:6]), 64'h3);
      rd(6'h20, v);
      chk("R6 alt A readback", 64'(v), 64'h0000_000A);
      rd(6'h24, v);
      chk("R6 alt B readback", 64'(v), 64'h0000_000C);
   endtask

   task automatic t_pull_sleep();
      logic [31:0] v;
      wr(6'h0C, 32'h8000_0003);
      chk("R7 pull_en", 64'(pull_en), 64'h7FFF_FFFC);
      rd(6'h0C, v);
      chk("R7 readback", 64'(v), 64'h8000_0003);
      wr(6'h1C, 32'h0000_F00D);
      chk("R8 sleep_keep", 64'(sleep_keep), 64'h0000_F00D);
      rd(6'h1C, v);
      chk("R8 readback", 64'(v), 64'h0000_F00D);
   endtask

   task automatic t_stray();
      logic [31:0] v;
      logic [NPIN-1:0]   po, oe;
      logic [2*NPIN-1:0] fs;
      wr(6'h14, 32'h0000_FFFF);
      po = pad_out; oe = pad_oe; fs = func_sel;
      wr(6'h28, 32'hFFFF_FFFF);   // unmapped
      wr(6'h05, 32'hFFFF_FFFF);   // misaligned
      wr(6'h21, 32'hFFFF_FFFF);   // misaligned near alt A
      wr(6'h00, 32'hFFFF_FFFF);   // read-only level
      wr(6'h10, 32'h0);           // read-only direction
      chk("R9 pad_out unchanged", 64'(pad_out), 64'(po));
      chk("R9 pad_oe unchanged", 64'(pad_oe), 64'(oe));
      chk("R9 func_sel unchanged", func_sel, fs);
      rd(6'h28, v);
      chk("R9 unmapped reads 0", 64'(v), 64'h0);
      rd(6'h21, v);
      chk("R9 misaligned reads 0", 64'(v), 64'h0);
      rd(6'h04, v);
      chk("R9 set offset reads 0", 64'(v), 64'h0);
      rd(6'h18, v);
      chk("R9 clear offset reads 0", 64'(v), 64'h0);
   endtask

   task automatic t_no_wren();
      logic [NPIN-1:0] po, slp;
      po = pad_out; slp = sleep_keep;
      @(negedge clk);
      addr = 6'h08; wr_data = 32'hFFFF_FFFF; wr_en = 1'b0;
      @(negedge clk);
      addr = 6'h1C;
      @(negedge clk);
      chk("R10 pad_out held", 64'(pad_out), 64'(po));
      chk("R10 sleep held", 64'(sleep_keep), 64'(slp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      t_data();
      t_sync();
      t_func();
      t_pull_sleep();
      t_stray();
      t_no_wren();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule